// File: doc/BRIEF.md
# Time-Aligned Periodic Sync Pulse Generator

This block drives one pulse line whose rising edges sit on fixed instants of a shared nanosecond time-of-day count. Every node that sees the same disciplined count and holds the same settings raises its line at the same instant, so separate controllers can sample or lock their carriers together. An edge lands where the count crosses a whole multiple of the programmed period. A signed offset then moves that point earlier or later, which removes a fixed bias in the path behind the pin. The pulse stays high for a programmed width and then falls.

A host writes a period, a width and an offset and strobes a load. Legal settings are held as pending. They become active only at the next boundary the generator fires, or at once while the generator is disabled. Illegal settings raise an error flag and leave both the pending and the active settings untouched. A forward jump of the time count does not cause a burst. The generator finds the next future grid point and carries on from there.

Control is a five-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | Disabled. |
| `ST_ALIGN` | A serial remainder of the time snapshot by the period is being computed. |
| `ST_PLACE` | The first target is being stepped past the current time. |
| `ST_WAIT` | Armed for the next edge. |
| `ST_HIGH` | The pulse is being driven. |

Transitions:
- IDLE→ALIGN when enable is high.
- ALIGN→PLACE when the remainder is ready.
- PLACE→PLACE while the target is not in the future, with the target advanced by one period each time.
- PLACE→WAIT once the target is in the future.
- WAIT→HIGH when the time reaches the edge, before edge+width.
- WAIT→ALIGN when the time is already at or past edge+width (missed edge).
- HIGH→WAIT at edge+width.
- HIGH→ALIGN at edge+width when a pending setting was captured at the edge.
- Any state→IDLE when enable is low.

Top module: `sp_sync_pulse_gen`

## Requirements
- R1: A rising edge of `pulse_out` is produced in the cycle after the first clock edge at which `tod_ns` is at or above a point k·period + offset. With a time step that divides the grid, that sampled time equals the grid point exactly.
- R2: After a rise, `pulse_out` stays high until the clock edge at which `tod_ns` reaches edge + width, and is low in the following cycle.
- R3: `cfg_offset` is a two's-complement nanosecond shift. A positive value delays every edge and a negative value advances it, relative to the multiples of the period.
- R4: When `tod_ns` jumps forward past edge + width, no pulse is emitted for the missed points. The next rise falls on the first grid point after the jump, and no two rises are closer than one period.
- R5: A load with width equal to zero, or with width at or above the period, sets `cfg_err` in the next cycle. The active and pending settings stay as they were.
- R6: A legal load clears `cfg_err` in the next cycle. While enabled, the new setting takes effect only after the first rise that fires at a clock edge after the load's edge. A rise in the same cycle as the load still uses the old setting, and the following rise comes one old period later.
- R7: From the cycle after `enable` is sampled low, `pulse_out` is low, even in the middle of a pulse. A load while disabled becomes active at once. After `enable` rises, the first rise is on the grid of the active setting.
- R8: After reset, `pulse_out` and `cfg_err` are low. The active setting is period 500000 ns, width 10000 ns, offset 0 (2 kHz). A 500 Hz setting with a 10 us width runs correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the generator; low holds the line low |
| tod_ns | input | TIME_W | Shared time-of-day count in ns |
| cfg_load | input | 1 | One-cycle strobe to capture a new setting |
| cfg_period | input | CFG_W | Period in ns |
| cfg_width | input | CFG_W | High time in ns |
| cfg_offset | input | CFG_W | Signed edge shift in ns |
| pulse_out | output | 1 | Synchronization pulse |
| cfg_err | output | 1 | Last load was illegal |

## Verification
The critical overlap is a load strobe sampled at the same clock edge at which the generator fires a boundary. In that case the pending capture must not affect the edge that is already firing. The bench provokes this by waiting until the time value about to be sampled is a grid point and raising the load in that exact cycle. It then confirms that a rise appears at that grid point and that the next rise follows exactly one old period later. Every rise after that is judged against the new grid. A second overlap is provoked by dropping enable while the pulse is high: the line must fall at once, and the width check is suspended for that pulse.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_PLACE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_HIGH  = 3'd4
    } sp_state_e;
endpackage

// File: rtl/sp_rem_div.sv
module sp_rem_div #(
    parameter int DVD_W = 64,
    parameter int DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic             done,
    output logic [DIV_W-1:0] rem
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] dvd_q;
    logic [DIV_W-1:0] r_q;
    logic [DIV_W-1:0] div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;
    logic [DIV_W:0]   shifted;
    logic [DIV_W:0]   diff;
    logic             ge;

    always_comb begin
        shifted = {r_q, dvd_q[DVD_W-1]};
        ge      = shifted >= {1'b0, div_q};
        diff    = shifted - {1'b0, div_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dvd_q  <= '0;
            r_q    <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (start) begin
            dvd_q  <= dividend;
            r_q    <= '0;
            div_q  <= divisor;
            cnt_q  <= CNT_W'(DVD_W);
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            r_q   <= ge ? diff[DIV_W-1:0] : shifted[DIV_W-1:0];
            dvd_q <= dvd_q << 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    assign done = done_q;
    assign rem  = r_q;

    // R1: the grid base is only exact if the remainder is reduced
    assert_rem_below_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (r_q < div_q));
endmodule

// File: rtl/sp_cfg_stage.sv
module sp_cfg_stage #(
    parameter int CFG_W      = 32,
    parameter int DEF_PERIOD = 500000,
    parameter int DEF_WIDTH  = 10000,
    parameter int DEF_OFFSET = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] new_period,
    input  logic [CFG_W-1:0] new_width,
    input  logic [CFG_W-1:0] new_offset,
    input  logic             apply,
    output logic [CFG_W-1:0] act_period,
    output logic [CFG_W-1:0] act_width,
    output logic [CFG_W-1:0] act_offset,
    output logic [CFG_W-1:0] pend_period,
    output logic             pend_valid,
    output logic             err
);
    logic [CFG_W-1:0] pend_width;
    logic [CFG_W-1:0] pend_offset;
    logic             legal;

    assign legal = (new_width != '0) && (new_width < new_period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_period  <= CFG_W'(DEF_PERIOD);
            act_width   <= CFG_W'(DEF_WIDTH);
            act_offset  <= CFG_W'(DEF_OFFSET);
            pend_period <= '0;
            pend_width  <= '0;
            pend_offset <= '0;
            pend_valid  <= 1'b0;
            err         <= 1'b0;
        end else begin
            if (apply) begin
                act_period <= pend_period;
                act_width  <= pend_width;
                act_offset <= pend_offset;
            end
            if (load && legal) begin
                pend_period <= new_period;
                pend_width  <= new_width;
                pend_offset <= new_offset;
                pend_valid  <= 1'b1;
            end else if (apply) begin
                pend_valid  <= 1'b0;
            end
            if (load) begin
                err <= !legal;
            end
        end
    end

    assert_bad_load_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal && !apply) |=> (err && $stable(pend_period) && $stable(pend_valid)));

    assert_good_load_staged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && legal) |=> (!err && pend_valid));
endmodule

// File: rtl/sp_sync_pulse_gen.sv
module sp_sync_pulse_gen #(
    parameter int TIME_W     = 64,
    parameter int CFG_W      = 32,
    parameter int DEF_PERIOD = 500000,
    parameter int DEF_WIDTH  = 10000,
    parameter int DEF_OFFSET = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [TIME_W-1:0]       tod_ns,
    input  logic                    cfg_load,
    input  logic [CFG_W-1:0]        cfg_period,
    input  logic [CFG_W-1:0]        cfg_width,
    input  logic signed [CFG_W-1:0] cfg_offset,
    output logic                    pulse_out,
    output logic                    cfg_err
);
    import sp_pkg::*;

    localparam int EXT_W = TIME_W - CFG_W;

    sp_state_e state_q, state_d;

    logic [TIME_W-1:0] mult_q;
    logic [TIME_W-1:0] snap_q;
    logic              swap_q;

    logic [CFG_W-1:0]  act_period, act_width, act_offset, pend_period;
    logic              pend_valid;
    logic              stage_err;
    logic              apply_cfg;
    logic              div_start;
    logic              div_done;
    logic [CFG_W-1:0]  div_rem;
    logic [CFG_W-1:0]  div_divisor;

    logic [TIME_W-1:0] per_ext, off_ext, wid_ext, rem_ext;
    logic [TIME_W-1:0] edge_t, end_t;
    logic              at_edge, past_end;

    sp_cfg_stage #(
        .CFG_W(CFG_W), .DEF_PERIOD(DEF_PERIOD),
        .DEF_WIDTH(DEF_WIDTH), .DEF_OFFSET(DEF_OFFSET)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .new_period(cfg_period), .new_width(cfg_width), .new_offset(cfg_offset),
        .apply(apply_cfg),
        .act_period(act_period), .act_width(act_width), .act_offset(act_offset),
        .pend_period(pend_period), .pend_valid(pend_valid), .err(stage_err)
    );

    sp_rem_div #(.DVD_W(TIME_W), .DIV_W(CFG_W)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .dividend(tod_ns), .divisor(div_divisor),
        .done(div_done), .rem(div_rem)
    );

    // target arithmetic
    always_comb begin
        per_ext  = {{EXT_W{1'b0}}, act_period};
        wid_ext  = {{EXT_W{1'b0}}, act_width};
        off_ext  = {{EXT_W{act_offset[CFG_W-1]}}, act_offset};
        rem_ext  = {{EXT_W{1'b0}}, div_rem};
        edge_t   = mult_q + off_ext;
        end_t    = edge_t + wid_ext;
        at_edge  = tod_ns >= edge_t;
        past_end = tod_ns >= end_t;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable) state_d = ST_ALIGN;
            ST_ALIGN: if (!enable) state_d = ST_IDLE;
                      else if (div_done) state_d = ST_PLACE;
            ST_PLACE: if (!enable) state_d = ST_IDLE;
                      else if (!at_edge) state_d = ST_WAIT;
            ST_WAIT:  if (!enable) state_d = ST_IDLE;
                      else if (at_edge) state_d = past_end ? ST_ALIGN : ST_HIGH;
            ST_HIGH:  if (!enable) state_d = ST_IDLE;
                      else if (past_end) state_d = swap_q ? ST_ALIGN : ST_WAIT;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        div_start   = (state_d == ST_ALIGN) && (state_q != ST_ALIGN);
        apply_cfg   = pend_valid &&
                      ((state_q == ST_IDLE) ||
                       (div_start && ((state_q != ST_HIGH) || swap_q)));
        div_divisor = apply_cfg ? pend_period : act_period;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // target bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mult_q <= '0;
            snap_q <= '0;
            swap_q <= 1'b0;
        end else begin
            if (div_start) snap_q <= tod_ns;
            if (state_q == ST_IDLE) swap_q <= 1'b0;
            if (state_q == ST_ALIGN && div_done)
                mult_q <= snap_q - rem_ext + per_ext;
            if (state_q == ST_PLACE && enable && at_edge)
                mult_q <= mult_q + per_ext;
            if (state_q == ST_WAIT && state_d == ST_HIGH)
                swap_q <= pend_valid;
            if (state_q == ST_HIGH && state_d == ST_WAIT)
                mult_q <= mult_q + per_ext;
            if (state_q == ST_HIGH && state_d == ST_ALIGN)
                swap_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        pulse_out = (state_q == ST_HIGH);
        cfg_err   = stage_err;
    end

    assert_rise_on_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> (($past(tod_ns) >= $past(edge_t)) && ($past(tod_ns) < $past(end_t))));

    assert_fall_at_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_out) && $past(enable)) |-> ($past(tod_ns) >= $past(end_t)));

    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pulse_out);

    assert_place_future_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLACE && state_d == ST_WAIT) |-> (edge_t > tod_ns));
endmodule

// File: tb/sp_sync_pulse_gen_tb_top.sv
module sp_sync_pulse_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [63:0] tod_ns = 64'd1000000000;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_period = '0;
    logic [31:0] cfg_width = '0;
    logic signed [31:0] cfg_offset = '0;
    logic        pulse_out;
    logic        cfg_err;

    always #2 clk = ~clk;

    sp_sync_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tod_ns(tod_ns),
        .cfg_load(cfg_load), .cfg_period(cfg_period), .cfg_width(cfg_width),
        .cfg_offset(cfg_offset), .pulse_out(pulse_out), .cfg_err(cfg_err)
    );

    int     errors = 0;
    int     checks = 0;
    bit     finished = 0;
    longint tstep = 400;
    longint cur_per = 500000, cur_wid = 10000, cur_off = 0;
    longint new_per, new_wid, new_off;
    int     pend = 0;
    bit     track = 0;
    bit     en_chk = 0;
    bit     prev_out = 0;
    longint last_rise = 0;
    bit     last_valid = 0;
    longint high_cnt = 0;
    longint rise_wid = 0;
    bit     rose_now = 0;
    longint rise_tod = 0;
    int     rise_count = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        longint t;
        @(negedge clk);
        t = longint'(tod_ns);
        rose_now = 0;
        if (!en_chk) begin
            chk(pulse_out == 1'b0, "R7 low while disabled", longint'(pulse_out), 0);
        end else if (track) begin
            if (pulse_out && !prev_out) begin
                rose_now = 1; rise_tod = t; rise_count++;
                chk(((t - cur_off) % cur_per) == 0, "R1 rise on grid", (t - cur_off) % cur_per, 0);
                if (last_valid)
                    chk((t - last_rise) >= cur_per, "R4 rise spacing", t - last_rise, cur_per);
                last_rise = t; last_valid = 1; high_cnt = 1; rise_wid = cur_wid;
                if (pend == 2) begin
                    cur_per = new_per; cur_wid = new_wid; cur_off = new_off;
                    pend = 0; last_valid = 0;
                end
            end else if (pulse_out) begin
                high_cnt++;
            end else if (prev_out) begin
                chk(high_cnt == rise_wid / tstep, "R2 high time", high_cnt, rise_wid / tstep);
            end
        end
        prev_out = pulse_out;
        if (pend == 1) pend = 2;
        cfg_load = 1'b0;
        tod_ns = tod_ns + 64'(tstep);
    endtask

    task automatic drive_load(input longint p, input longint w, input longint o);
        cfg_load = 1'b1;
        cfg_period = 32'(p); cfg_width = 32'(w); cfg_offset = 32'(o);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_enable(input bit v);
        enable = v; en_chk = v; track = v; last_valid = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        longint old_per, coin, land, expn, base_cnt;
        bit got;
        run(4);
        rst_n = 1'b1;
        tick();
        // R8 reset state
        chk(pulse_out == 1'b0, "R8 reset pulse low", longint'(pulse_out), 0);
        chk(cfg_err == 1'b0, "R8 reset err low", longint'(cfg_err), 0);

        // R8 default setting, 400 ns per cycle
        set_enable(1);
        base_cnt = rise_count;
        run(3000);
        chk(rise_count - base_cnt >= 2, "R8 default rises", rise_count - base_cnt, 2);

        // R8 500 Hz with 10 us width, loaded while running
        drive_load(2000000, 10000, 0);
        new_per = 2000000; new_wid = 10000; new_off = 0; pend = 1;
        for (int i = 0; i < 3000 && pend != 0; i++) tick();
        chk(pend == 0, "R6 pending applied after boundary", pend, 0);
        base_cnt = rise_count;
        run(12000);
        chk(rise_count - base_cnt >= 2, "R8 500Hz rises", rise_count - base_cnt, 2);

        // R7 disable, load while disabled, finer time step
        set_enable(0);
        run(20);
        tstep = 4;
        drive_load(2000, 400, 12);
        cur_per = 2000; cur_wid = 400; cur_off = 12;
        run(5);
        set_enable(1);
        got = 0;
        for (int i = 0; i < 1500 && !got; i++) begin
            tick();
            if (rose_now) got = 1;
        end
        chk(got, "R7 first rise after enable", longint'(got), 1);
        chk((rise_tod % 2000) == 12, "R3 positive offset", rise_tod % 2000, 12);
        run(2500);

        // R6 load coinciding with a firing boundary
        old_per = cur_per;
        for (int i = 0; i < 1000 && ((longint'(tod_ns) - cur_off) % cur_per) != 0; i++) tick();
        drive_load(1600, 200, -8);
        new_per = 1600; new_wid = 200; new_off = -8; pend = 1;
        tick();
        chk(rose_now, "R6 rise in load cycle", longint'(rose_now), 1);
        coin = rise_tod;
        got = 0;
        for (int i = 0; i < 1000 && !got; i++) begin
            tick();
            if (rose_now) got = 1;
        end
        chk(rise_tod - coin == old_per, "R6 next rise on old period", rise_tod - coin, old_per);
        chk(cur_per == 1600, "R6 new setting taken", cur_per, 1600);
        run(3000);

        // R5 illegal loads
        drive_load(1600, 1600, 0);
        tick();
        chk(cfg_err == 1'b1, "R5 width equal period", longint'(cfg_err), 1);
        drive_load(2000, 0, 0);
        tick();
        chk(cfg_err == 1'b1, "R5 zero width", longint'(cfg_err), 1);
        base_cnt = rise_count;
        run(2000);
        chk(rise_count - base_cnt >= 4, "R5 old setting still running", rise_count - base_cnt, 4);
        drive_load(1600, 200, -8);
        new_per = 1600; new_wid = 200; new_off = -8; pend = 1;
        tick();
        chk(cfg_err == 1'b0, "R6 legal load clears err", longint'(cfg_err), 0);
        run(1000);

        // R4 forward jump from mid-gap
        for (int i = 0; i < 1000 &&
             (((longint'(tod_ns) - cur_off) % cur_per) != cur_per / 2 || pulse_out); i++) tick();
        tod_ns = tod_ns + 64'(10 * cur_per);
        land = longint'(tod_ns);
        expn = land + cur_per / 2;
        got = 0;
        for (int i = 0; i < 400 && !got; i++) begin
            tick();
            if (rose_now) got = 1;
        end
        chk(got, "R4 rise after jump", longint'(got), 1);
        chk(rise_tod == expn, "R4 realigned rise", rise_tod, expn);
        chk((rise_tod % 1600) == 1600 - 8, "R3 negative offset", rise_tod % 1600, 1592);
        run(1500);

        // R7 drop enable in the middle of a pulse
        for (int i = 0; i < 1000 && !pulse_out; i++) tick();
        chk(pulse_out == 1'b1, "R7 pulse high before drop", longint'(pulse_out), 1);
        set_enable(0);
        run(30);
        set_enable(1);
        base_cnt = rise_count;
        run(2000);
        chk(rise_count - base_cnt >= 3, "R7 rises after re-enable", rise_count - base_cnt, 3);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule